// File: doc/BRIEF.md
# Isolated Cell Excitation and Converter Scan Sequencer

This block paces a periodic measurement sweep over eight isolated cell channels. A programmable timer issues a tick; on each tick the sequencer runs eight slots. In a slot it loads a one-hot word into an external parallel latch that gates the excitation transformer of one channel, pulses the latch strobe, opens an SPI frame to an external converter, sends the converter's next-channel configuration while receiving the upper half of the previous conversion, then turns on the excitation, waits a programmable settling time, receives the lower half, closes the frame (which starts the next conversion) and drops the excitation.

Because the converter returns the conversion started at the end of the previous frame, the latch words and configuration words are skewed: the result read in slot s is the conversion of channel s, and it is stored in result register s unless software has locked that register. Holding the excitation off until the first byte has finished keeps the excitation pulse short and independent of the first byte's transfer. A bus-busy input defers the start of any slot, and a tick that arrives during a sweep is dropped and recorded in a sticky flag.

Top module: `cellscan_seq`

## Requirements
- R1: A tick is generated every `cfg_period` system clocks; each tick taken while idle starts a sweep of eight slots, and `scan_done` pulses for one clock after the eighth slot, so successive `scan_done` pulses are `cfg_period` clocks apart.
- R2: The latch words of slots 0..7 are 0x40, 0x20, 0x10, 0x08, 0x04, 0x02, 0x01, 0x80, each with exactly one bit set and stable while `latch_stb` is high.
- R3: The first byte sent in slots 0..7 is 0xC4, 0x94, 0xD4, 0xA4, 0xE4, 0xB4, 0xF4, 0x84: bit 7 = 1, bit 6 = converter input bit 0, bits 5:4 = input bits 2:1, bits 3:0 = 0100 (single-ended, unipolar), for converter inputs 1..7 then 0.
- R4: In each slot the latch word is set, `latch_stb` is high for exactly one clock, then low for one clock, and `spi_cs_n` falls on the next clock.
- R5: `excite` rises only while `spi_cs_n` is low and after the eighth rising `spi_sclk` edge of the frame; the gap before the second byte lasts `cfg_settle`+1 clocks, so the excitation width grows by one clock per unit of `cfg_settle`; the second byte sent is 0x00.
- R6: `spi_cs_n` rises at the end of the sixteenth bit and `excite` falls exactly one clock later, so they overlap high for one clock per slot.
- R7: `spi_sclk` is low whenever `spi_cs_n` is high and idles low; each bit is four system clocks (two low, two high); `spi_mosi` never changes while `spi_sclk` stays high; the 16 bits are MSB first, received on the rising edge.
- R8: The 16-bit word received in slot s (first byte in bits 15:8) is written to result register s, read through `rd_addr`/`rd_data` with one clock of latency; the word therefore holds the conversion started at the end of slot s-1.
- R9: A slot does not begin (no strobe, no frame) while `bus_busy` is high; it begins once `bus_busy` is low.
- R10: A tick arriving while a sweep is in progress is dropped and sets `overrun`, which stays set until reset.
- R11: After reset `spi_cs_n` is high, `spi_sclk`, `excite`, `latch_stb`, `scan_done` and `overrun` are low, and `latch_d` is zero.
- R12: While `rd_lock[s]` is 1 at the end of slot s, result register s keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_period | input | PERIOD_W | Sweep period in system clocks |
| cfg_settle | input | SETTLE_W | Settling wait; gap is this value plus one clock |
| bus_busy | input | 1 | Defers the start of the next slot while high |
| rd_lock | input | 8 | Per-register write inhibit |
| rd_addr | input | 3 | Result register select |
| rd_data | output | 16 | Selected result, one clock after the address |
| latch_d | output | 8 | One-hot excitation-enable word to the external latch |
| latch_stb | output | 1 | Latch load strobe |
| excite | output | 1 | Transformer excitation drive |
| spi_cs_n | output | 1 | Converter chip select, low during a frame |
| spi_sclk | output | 1 | Serial clock, system clock divided by four |
| spi_mosi | output | 1 | Serial data to the converter |
| spi_miso | input | 1 | Serial data from the converter |
| scan_done | output | 1 | One-clock pulse after the eighth slot |
| overrun | output | 1 | Sticky flag: a tick arrived during a sweep |

## Verification
The bench builds the block with its default widths, a 16-bit period and an 8-bit settle field, and drives a period of 1500 clocks so that a full sweep with two different settle values fits inside one period; later it lowers the period to 300 clocks, shorter than a sweep, which brings the dropped-tick path into reach. A behavioural converter returns its own configuration byte and a per-sweep tag, so the skew between slot and stored channel, the lock inhibit and the width change of the excitation pulse become visible at the ports.

// File: rtl/cellscan_pkg.sv
package cellscan_pkg;

  localparam int NCH    = 8;
  localparam int CHW    = $clog2(NCH);
  localparam int BYTE_W = 8;
  localparam int RES_W  = 2 * BYTE_W;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAIT,
    ST_STBH,
    ST_STBL,
    ST_CSLO,
    ST_BYTE1,
    ST_SETTLE,
    ST_BYTE2,
    ST_EXOFF,
    ST_STORE
  } seq_state_t;

  // One-hot gate word for a slot: bits 6 down to 0, then bit 7.
  function automatic logic [BYTE_W-1:0] enable_for_slot(input logic [CHW-1:0] s);
    logic [CHW-1:0] b;
    b = (s == CHW'(NCH - 1)) ? CHW'(NCH - 1) : CHW'(NCH - 2) - s;
    return BYTE_W'(1) << b;
  endfunction

  // Converter command for a slot: next input is slot+1 (wrapping).
  function automatic logic [BYTE_W-1:0] cmd_for_slot(input logic [CHW-1:0] s);
    logic [CHW-1:0] inp;
    inp = s + CHW'(1);
    return {1'b1, inp[0], inp[2:1], 4'b0100};
  endfunction

endpackage

// File: rtl/cellscan_tick.sv
module cellscan_tick #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PERIOD_W-1:0] period,
  output logic                tick
);
  logic [PERIOD_W-1:0] cnt;
  logic [PERIOD_W:0]   nxt;

  assign nxt = {1'b0, cnt} + (PERIOD_W+1)'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (nxt >= {1'b0, period}) begin
        cnt  <= '0;
        tick <= 1'b1;
      end else begin
        cnt <= nxt[PERIOD_W-1:0];
      end
    end
  end
endmodule

// File: rtl/cellscan_spi.sv
module cellscan_spi #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [BYTE_W-1:0] tx,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic [BYTE_W-1:0] rx,
  output logic              done
);
  localparam int BW = $clog2(BYTE_W);

  logic [1:0]        ph;
  logic [BW-1:0]     bitn;
  logic              busy;
  logic [BYTE_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= '0;
      bitn <= '0;
      busy <= 1'b0;
      sh   <= '0;
      sclk <= 1'b0;
      mosi <= 1'b0;
      rx   <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        ph   <= '0;
        bitn <= BW'(BYTE_W - 1);
        sh   <= tx;
        mosi <= tx[BYTE_W-1];
        sclk <= 1'b0;
      end else if (busy) begin
        ph <= ph + 2'd1;
        if (ph == 2'd1) begin
          sclk <= 1'b1;
        end else if (ph == 2'd2) begin
          rx <= {rx[BYTE_W-2:0], miso};
        end else if (ph == 2'd3) begin
          sclk <= 1'b0;
          if (bitn == '0) begin
            busy <= 1'b0;
            done <= 1'b1;
            mosi <= 1'b0;
          end else begin
            bitn <= bitn - BW'(1);
            sh   <= {sh[BYTE_W-2:0], 1'b0};
            mosi <= sh[BYTE_W-2];
          end
        end
      end
    end
  end
endmodule

// File: rtl/cellscan_bank.sv
module cellscan_bank #(
  parameter int DEPTH = 8,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr];
  end
endmodule

// File: rtl/cellscan_seq.sv
module cellscan_seq
  import cellscan_pkg::*;
#(
  parameter int PERIOD_W = 16,
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PERIOD_W-1:0] cfg_period,
  input  logic [SETTLE_W-1:0] cfg_settle,
  input  logic                bus_busy,
  input  logic [NCH-1:0]      rd_lock,
  input  logic [CHW-1:0]      rd_addr,
  output logic [RES_W-1:0]    rd_data,
  output logic [BYTE_W-1:0]   latch_d,
  output logic                latch_stb,
  output logic                excite,
  output logic                spi_cs_n,
  output logic                spi_sclk,
  output logic                spi_mosi,
  input  logic                spi_miso,
  output logic                scan_done,
  output logic                overrun
);
  seq_state_t          state;
  logic [CHW-1:0]      slot;
  logic [SETTLE_W-1:0] wait_cnt;
  logic [BYTE_W-1:0]   hi_byte;
  logic [BYTE_W-1:0]   lo_byte;
  logic                tick;
  logic                sh_start;
  logic [BYTE_W-1:0]   sh_tx;
  logic [BYTE_W-1:0]   sh_rx;
  logic                sh_done;
  logic                bank_we;

  cellscan_tick #(.PERIOD_W(PERIOD_W)) tick_i (
    .clk(clk), .rst(rst), .period(cfg_period), .tick(tick)
  );

  // First byte starts with chip select, second after the settling wait.
  assign sh_start = (state == ST_CSLO) || (state == ST_SETTLE && wait_cnt == '0);
  assign sh_tx    = (state == ST_CSLO) ? cmd_for_slot(slot) : '0;

  cellscan_spi #(.BYTE_W(BYTE_W)) spi_i (
    .clk(clk), .rst(rst), .start(sh_start), .tx(sh_tx), .miso(spi_miso),
    .sclk(spi_sclk), .mosi(spi_mosi), .rx(sh_rx), .done(sh_done)
  );

  assign bank_we = (state == ST_STORE) && !rd_lock[slot];

  cellscan_bank #(.DEPTH(NCH), .DW(RES_W)) bank_i (
    .clk(clk), .rst(rst), .we(bank_we), .waddr(slot),
    .wdata({hi_byte, lo_byte}), .raddr(rd_addr), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      slot      <= '0;
      wait_cnt  <= '0;
      hi_byte   <= '0;
      lo_byte   <= '0;
      latch_d   <= '0;
      latch_stb <= 1'b0;
      excite    <= 1'b0;
      spi_cs_n  <= 1'b1;
      scan_done <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      scan_done <= 1'b0;
      if (tick && state != ST_IDLE) overrun <= 1'b1;
      case (state)
        ST_IDLE: if (tick) begin
          slot  <= '0;
          state <= ST_WAIT;
        end
        ST_WAIT: if (!bus_busy) begin
          latch_d <= enable_for_slot(slot);
          state   <= ST_STBH;
        end
        ST_STBH: begin
          latch_stb <= 1'b1;
          state     <= ST_STBL;
        end
        ST_STBL: begin
          latch_stb <= 1'b0;
          state     <= ST_CSLO;
        end
        ST_CSLO: begin
          spi_cs_n <= 1'b0;
          state    <= ST_BYTE1;
        end
        ST_BYTE1: if (sh_done) begin
          hi_byte  <= sh_rx;
          excite   <= 1'b1;
          wait_cnt <= cfg_settle;
          state    <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (wait_cnt == '0) state <= ST_BYTE2;
          else                wait_cnt <= wait_cnt - SETTLE_W'(1);
        end
        ST_BYTE2: if (sh_done) begin
          lo_byte  <= sh_rx;
          spi_cs_n <= 1'b1;
          state    <= ST_EXOFF;
        end
        ST_EXOFF: begin
          excite <= 1'b0;
          state  <= ST_STORE;
        end
        ST_STORE: begin
          if (slot == CHW'(NCH - 1)) begin
            scan_done <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            slot  <= slot + CHW'(1);
            state <= ST_WAIT;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cellscan_chk.sv
module cellscan_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_busy,
  input logic [7:0] latch_d,
  input logic       latch_stb,
  input logic       excite,
  input logic       cs_n,
  input logic       sclk,
  input logic       overrun
);
  assert_sclk_idle_R7: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  assert_exc_in_frame_R5: assert property (@(posedge clk) disable iff (rst)
    (excite && cs_n) |-> $rose(cs_n));

  assert_exc_off_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |=> !excite);

  assert_latch_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(latch_stb) |-> ($countones(latch_d) == 1));

  assert_strobe_width_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(latch_stb) |=> !latch_stb);

  assert_cs_after_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> ($past(latch_stb, 2) && !$past(latch_stb)));

  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(latch_stb) |-> !$past(bus_busy, 2));

  assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    $past(overrun) |-> overrun);
endmodule

bind cellscan_seq cellscan_chk chk_i (
  .clk(clk), .rst(rst), .bus_busy(bus_busy), .latch_d(latch_d),
  .latch_stb(latch_stb), .excite(excite), .cs_n(spi_cs_n),
  .sclk(spi_sclk), .overrun(overrun)
);

// File: tb/cellscan_seq_tb_top.sv
module cellscan_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cfg_period = 16'd1500;
  logic [7:0]  cfg_settle = 8'd8;
  logic        bus_busy = 1'b0;
  logic [7:0]  rd_lock = 8'h00;
  logic [2:0]  rd_addr = 3'd0;
  logic [15:0] rd_data;
  logic [7:0]  latch_d;
  logic        latch_stb, excite, spi_cs_n, spi_sclk, spi_mosi, scan_done, overrun;
  logic        spi_miso = 1'b0;

  cellscan_seq dut_i (
    .clk(clk), .rst(rst), .cfg_period(cfg_period), .cfg_settle(cfg_settle),
    .bus_busy(bus_busy), .rd_lock(rd_lock), .rd_addr(rd_addr), .rd_data(rd_data),
    .latch_d(latch_d), .latch_stb(latch_stb), .excite(excite),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .scan_done(scan_done), .overrun(overrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [7:0] exp_cmd [8] = '{8'hC4, 8'h94, 8'hD4, 8'hA4, 8'hE4, 8'hB4, 8'hF4, 8'h84};
  logic [7:0] exp_en  [8] = '{8'h40, 8'h20, 8'h10, 8'h08, 8'h04, 8'h02, 8'h01, 8'h80};

  // Converter model: returns {its last command byte, sweep tag}.
  logic [15:0] pending = 16'h1234;
  logic [15:0] txword = 16'h0;
  logic [15:0] rxsh = 16'h0;
  logic [7:0]  seed = 8'h11;
  int          bitidx = 0;
  logic [7:0]  cmd_rx [8];
  logic [7:0]  b2_rx [8];
  int          fi = 0;

  always @(negedge spi_cs_n) if (!rst) begin
    txword = pending;
    bitidx = 15;
    spi_miso = txword[15];
  end
  always @(negedge spi_sclk) if (!rst && spi_cs_n == 1'b0) begin
    bitidx = bitidx - 1;
    if (bitidx >= 0) spi_miso = txword[bitidx];
  end
  always @(posedge spi_sclk) if (!rst) rxsh = {rxsh[14:0], spi_mosi};
  always @(posedge spi_cs_n) if (!rst) begin
    cmd_rx[fi] = rxsh[15:8];
    b2_rx[fi]  = rxsh[7:0];
    pending    = {rxsh[15:8], seed};
    fi = (fi + 1) % 8;
  end

  // Port monitor
  logic [7:0] lat [8];
  int li = 0, stb_rises = 0, cs_falls = 0, frame_rises = 0, hi_len = 0;
  int spi_err = 0, exc_err = 0, exc_len = 0, last_w = 0, exc_cs_overlap = 0;
  int done_count = 0, cyc = 0, last_done_cyc = 0;
  logic p_stb = 0, p_sclk = 0, p_mosi = 0, p_exc = 0, p_cs = 1;

  always @(posedge clk) begin
    cyc++;
    if (!rst) begin
      if (latch_stb && !p_stb) begin lat[li] = latch_d; li = (li + 1) % 8; stb_rises++; end
      if (!spi_cs_n && p_cs) begin frame_rises = 0; cs_falls++; end
      if (spi_sclk && !p_sclk) begin frame_rises++; hi_len = 0; end
      if (spi_sclk) hi_len++;
      if (!spi_sclk && p_sclk && hi_len != 2) spi_err++;
      if (spi_sclk && p_sclk && spi_mosi != p_mosi) spi_err++;
      if (spi_sclk && spi_cs_n) spi_err++;
      if (excite && !p_exc) begin
        if (frame_rises != 8 || spi_cs_n) exc_err++;
        exc_len = 0;
      end
      if (excite) exc_len++;
      if (!excite && p_exc) last_w = exc_len;
      if (excite && spi_cs_n) exc_cs_overlap++;
      if (scan_done) begin done_count++; last_done_cyc = cyc; end
    end
    p_stb = latch_stb; p_sclk = spi_sclk; p_mosi = spi_mosi; p_exc = excite; p_cs = spi_cs_n;
  end

  task automatic wait_scan();
    int target = done_count + 1;
    int t = 0;
    while (done_count < target && t < 6000) begin @(negedge clk); t++; end
    chk(done_count >= target, "R1 scan_done seen", done_count, target);
  endtask

  task automatic rd(input int a, output logic [15:0] v);
    @(negedge clk) rd_addr = a[2:0];
    @(negedge clk) v = rd_data;
  endtask

  task automatic check_frames();
    for (int s = 0; s < 8; s++) begin
      chk(lat[s] == exp_en[s], "R2 latch word", lat[s], exp_en[s]);
      chk(cmd_rx[s] == exp_cmd[s], "R3 command byte", cmd_rx[s], exp_cmd[s]);
      chk(b2_rx[s] == 8'h00, "R5 second byte zero", b2_rx[s], 0);
    end
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    chk(spi_cs_n == 1'b1, "R11 cs_n high", spi_cs_n, 1);
    chk(spi_sclk == 1'b0 && excite == 1'b0, "R11 sclk/excite low", {spi_sclk, excite}, 0);
    chk(latch_stb == 1'b0 && latch_d == 8'h00, "R11 latch idle", {latch_stb, latch_d}, 0);
    chk(scan_done == 1'b0 && overrun == 1'b0, "R11 flags low", {scan_done, overrun}, 0);
    rst = 1'b0;
  endtask

  int w8 = 0;

  task automatic t_basic();
    logic [15:0] v;
    int t1, s0, c0;
    s0 = stb_rises; c0 = cs_falls;
    wait_scan();
    t1 = last_done_cyc;
    seed = 8'h22;
    w8 = last_w;
    check_frames();
    chk(stb_rises - s0 == 8, "R4 strobes per sweep", stb_rises - s0, 8);
    chk(cs_falls - c0 == 8, "R4 frames per sweep", cs_falls - c0, 8);
    chk(spi_err == 0, "R7 serial timing", spi_err, 0);
    chk(exc_err == 0, "R5 excite after first byte", exc_err, 0);
    chk(exc_cs_overlap == 8, "R6 excite drop after cs", exc_cs_overlap, 8);
    rd(0, v); chk(v == 16'h1234, "R8 reg0 first sweep", v, 16'h1234);
    for (int s = 1; s < 8; s++) begin
      rd(s, v); chk(v == {exp_cmd[s-1], 8'h11}, "R8 skewed result", v, {exp_cmd[s-1], 8'h11});
    end
    wait_scan();
    seed = 8'h33;
    chk(last_done_cyc - t1 == 1500, "R1 sweep period", last_done_cyc - t1, 1500);
    rd(0, v); chk(v == {8'h84, 8'h11}, "R8 reg0 wraps to last slot", v, {8'h84, 8'h11});
    rd(5, v); chk(v == {exp_cmd[4], 8'h22}, "R8 reg5 second sweep", v, {exp_cmd[4], 8'h22});
  endtask

  task automatic t_settle();
    cfg_settle = 8'd20;
    wait_scan();
    chk(last_w - w8 == 12, "R5 settle widens excitation", last_w - w8, 12);
    chk(spi_err == 0, "R7 serial timing with long settle", spi_err, 0);
    check_frames();
  endtask

  task automatic t_lock();
    logic [15:0] v;
    rd_lock = 8'h08;
    seed = 8'h44;
    wait_scan();
    rd_lock = 8'h00;
    rd(3, v); chk(v == {exp_cmd[2], 8'h33}, "R12 locked reg3 kept", v, {exp_cmd[2], 8'h33});
    rd(4, v); chk(v == {exp_cmd[3], 8'h44}, "R12 unlocked reg4 written", v, {exp_cmd[3], 8'h44});
  endtask

  task automatic t_busy();
    int s0, c0, d0;
    bus_busy = 1'b1;
    s0 = stb_rises; c0 = cs_falls; d0 = done_count;
    repeat (1200) @(negedge clk);
    chk(stb_rises == s0, "R9 no strobe while busy", stb_rises - s0, 0);
    chk(cs_falls == c0, "R9 no frame while busy", cs_falls - c0, 0);
    chk(done_count == d0, "R9 sweep held", done_count - d0, 0);
    bus_busy = 1'b0;
    wait_scan();
    chk(stb_rises - s0 == 8, "R9 sweep resumes", stb_rises - s0, 8);
  endtask

  task automatic t_overrun();
    int d0;
    chk(overrun == 1'b0, "R10 no overrun at long period", overrun, 0);
    d0 = done_count;
    cfg_period = 16'd300;
    repeat (2500) @(negedge clk);
    chk(overrun == 1'b1, "R10 overrun set", overrun, 1);
    chk(done_count > d0, "R10 sweeps still complete", done_count - d0, 1);
    chk(spi_err == 0, "R7 timing under overrun", spi_err, 0);
    repeat (300) @(negedge clk);
    chk(overrun == 1'b1, "R10 overrun sticky", overrun, 1);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_settle();
    t_lock();
    t_busy();
    t_overrun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule